// File: doc/BRIEF.md
# Low-Voltage Detect Filter and Status

This block sits behind an analog supply comparator and decides when a sagging supply is real enough to act on. The comparator output `vdd_low` is 1 while the supply is under the falling trip point and 0 once it has climbed back over the higher rising trip point. The hysteresis lives in the comparator, so the block sees one level signal. Two independent filters run on it. A short, strict filter on the CPU clock drives a reset request. A longer filter on the oscillator clock drives a status flag that software can read.

Each filter is a small state machine. The reset filter has the states RF_IDLE, RF_COUNT and RF_TRIP. Its transitions are IDLE→COUNT on a low sample, COUNT→IDLE on a high sample, COUNT→TRIP on the ninth consecutive low sample, and TRIP→IDLE on any high sample. The flag filter has the states FF_CLEAR, FF_ARMING, FF_SET and FF_RELEASE. Its transitions are CLEAR→ARMING on a low sample, ARMING→CLEAR on a high sample, ARMING→SET on the 36th consecutive low sample, SET→RELEASE on a high sample, RELEASE→SET on a low sample, and RELEASE→CLEAR on the 36th consecutive high sample.

The comparator input passes through a two-flop synchronizer into each clock domain. The flag passes through another two-flop synchronizer into the CPU domain, where a registered read port returns it.

Top module: `lowv_guard`

## Requirements
- R1: `lv_reset_req` rises after the ninth consecutive CPU-clock sample of `vdd_low`=1. Counting the two synchronizer stages, it is high after CPU edge 11 when `vdd_low` rose just before edge 1. A run of eight samples never asserts it.
- R2: With `lv_reset_req` high, a single CPU sample of `vdd_low`=0 drops it three edges later. The run count then restarts from zero, so a following low run of eight samples does not re-assert it.
- R3: The flag sets after 36 consecutive oscillator samples of `vdd_low`=1. A low run shorter than 32 samples leaves it at 0. A low run longer than 40 samples always leaves it at 1.
- R4: A set flag clears only after 36 consecutive oscillator samples of `vdd_low`=0. A shorter high gap followed by low keeps it set.
- R5: A read cycle (`bus_en`=1, `bus_we`=0) at address 0xFE0F returns the flag in bit 7 and 0 in bits 6..0 on `bus_rdata` after the next CPU edge. A read of any other address returns 0x00.
- R6: A write cycle (`bus_en`=1, `bus_we`=1) at 0xFE0F changes nothing: `bus_rdata` is 0x00 after it, and the flag read afterwards is unchanged.
- R7: `rst`, held high across at least two edges of each clock, clears `lv_reset_req`, the flag and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU clock: reset filter and read port |
| osc_clk | input | 1 | Oscillator clock: flag filter |
| rst | input | 1 | Synchronous reset, active high, seen in both domains |
| vdd_low | input | 1 | Comparator output: 1 = supply below falling trip, 0 = above rising trip |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write access (ignored), 0 = read access |
| bus_addr | input | ADDR_W | Access address |
| bus_rdata | output | DATA_W | Registered read data |
| lv_reset_req | output | 1 | Low-voltage reset request |

## Verification
The bench builds the block with its defaults: a run length of 9 for the reset filter, set and clear lengths of 36 for the flag, and a 32-to-40 acceptance window. It uses an 8 ns CPU clock against a 26 ns oscillator clock. These values are short enough that random low bursts of 1 to 14 CPU cycles cross the reset threshold from both sides many times. Oscillator bursts chosen on either side of the 32–40 window make the flag's "never set" and "must set" regions reachable. Directed cases hit runs of exactly 8 and 9, a one-cycle recovery gap, and a high gap shorter than the clear window.

// File: rtl/lowv_pkg.sv
`timescale 1ns/1ps
package lowv_pkg;
    typedef enum logic [1:0] {
        RF_IDLE,
        RF_COUNT,
        RF_TRIP
    } rf_state_e;

    typedef enum logic [1:0] {
        FF_CLEAR,
        FF_ARMING,
        FF_SET,
        FF_RELEASE
    } ff_state_e;
endpackage

// File: rtl/lowv_sync.sv
`timescale 1ns/1ps
module lowv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lowv_rst_filter.sv
`timescale 1ns/1ps
module lowv_rst_filter
    import lowv_pkg::*;
#(
    parameter int RUN_LEN = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic low_i,
    output logic req_o
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);
    localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

    rf_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RF_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RF_IDLE: begin
                if (low_i) begin
                    state_d = RF_COUNT;
                    cnt_d   = ONE;
                end
            end
            RF_COUNT: begin
                if (!low_i) begin
                    state_d = RF_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = RF_TRIP;
                    cnt_d   = FULL;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            RF_TRIP: begin
                if (!low_i) begin
                    state_d = RF_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = RF_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        req_o = (state_q == RF_TRIP);
    end
endmodule

// File: rtl/lowv_flag_filter.sv
`timescale 1ns/1ps
module lowv_flag_filter
    import lowv_pkg::*;
#(
    parameter int SET_LEN = 36,
    parameter int CLR_LEN = 36
) (
    input  logic clk,
    input  logic rst,
    input  logic low_i,
    output logic flag_o
);
    localparam int CMAX = (SET_LEN > CLR_LEN) ? SET_LEN : CLR_LEN;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] ONE      = CW'(1);
    localparam logic [CW-1:0] SET_LAST = CW'(SET_LEN - 1);
    localparam logic [CW-1:0] CLR_LAST = CW'(CLR_LEN - 1);

    ff_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FF_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FF_CLEAR: begin
                if (low_i) begin
                    state_d = FF_ARMING;
                    cnt_d   = ONE;
                end
            end
            FF_ARMING: begin
                if (!low_i) begin
                    state_d = FF_CLEAR;
                    cnt_d   = '0;
                end else if (cnt_q == SET_LAST) begin
                    state_d = FF_SET;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            FF_SET: begin
                if (!low_i) begin
                    state_d = FF_RELEASE;
                    cnt_d   = ONE;
                end
            end
            FF_RELEASE: begin
                if (low_i) begin
                    state_d = FF_SET;
                    cnt_d   = '0;
                end else if (cnt_q == CLR_LAST) begin
                    state_d = FF_CLEAR;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            default: begin
                state_d = FF_CLEAR;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        flag_o = (state_q == FF_SET) || (state_q == FF_RELEASE);
    end
endmodule

// File: rtl/lowv_guard.sv
`timescale 1ns/1ps
module lowv_guard #(
    parameter int                 RST_RUN     = 9,
    parameter int                 FLAG_SET    = 36,
    parameter int                 FLAG_CLR    = 36,
    parameter int                 SYNC_STAGES = 2,
    parameter int                 ADDR_W      = 16,
    parameter int                 DATA_W      = 8,
    parameter int                 FLAG_BIT    = 7,
    parameter logic [ADDR_W-1:0]  STAT_ADDR   = 'hFE0F
) (
    input  logic              cpu_clk,
    input  logic              osc_clk,
    input  logic              rst,
    input  logic              vdd_low,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              lv_reset_req
);
    logic low_cpu;
    logic low_osc;
    logic flag_osc;
    logic flag_cpu;
    logic rd_hit;
    logic [DATA_W-1:0] rdata_q;

    lowv_sync #(.STAGES(SYNC_STAGES)) u_sync_cpu (
        .clk (cpu_clk), .rst (rst), .d_i (vdd_low), .q_o (low_cpu)
    );

    lowv_sync #(.STAGES(SYNC_STAGES)) u_sync_osc (
        .clk (osc_clk), .rst (rst), .d_i (vdd_low), .q_o (low_osc)
    );

    lowv_rst_filter #(.RUN_LEN(RST_RUN)) u_rst_filt (
        .clk (cpu_clk), .rst (rst), .low_i (low_cpu), .req_o (lv_reset_req)
    );

    lowv_flag_filter #(.SET_LEN(FLAG_SET), .CLR_LEN(FLAG_CLR)) u_flag_filt (
        .clk (osc_clk), .rst (rst), .low_i (low_osc), .flag_o (flag_osc)
    );

    lowv_sync #(.STAGES(SYNC_STAGES)) u_sync_flag (
        .clk (cpu_clk), .rst (rst), .d_i (flag_osc), .q_o (flag_cpu)
    );

    assign rd_hit = bus_en && !bus_we && (bus_addr == STAT_ADDR);

    always_ff @(posedge cpu_clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= '0;
            if (rd_hit) rdata_q[FLAG_BIT] <= flag_cpu;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/lowv_guard_chk.sv
`timescale 1ns/1ps
module lowv_guard_chk #(
    parameter int                 RST_RUN   = 9,
    parameter int                 FLAG_CLR  = 36,
    parameter int                 FLAG_MIN  = 32,
    parameter int                 FLAG_MAX  = 40,
    parameter int                 ADDR_W    = 16,
    parameter int                 DATA_W    = 8,
    parameter int                 FLAG_BIT  = 7,
    parameter logic [ADDR_W-1:0]  STAT_ADDR = 'hFE0F
) (
    input logic              cpu_clk,
    input logic              osc_clk,
    input logic              rst,
    input logic              low_cpu,
    input logic              low_osc,
    input logic              flag_osc,
    input logic              flag_cpu,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              lv_reset_req
);
    localparam int RW = $clog2(RST_RUN + 1);
    localparam int OM = (FLAG_MAX > FLAG_CLR) ? FLAG_MAX : FLAG_CLR;
    localparam int OW = $clog2(OM + 1);
    localparam logic [RW-1:0] RUN_V = RW'(RST_RUN);
    localparam logic [OW-1:0] MIN_V = OW'(FLAG_MIN);
    localparam logic [OW-1:0] MAX_V = OW'(FLAG_MAX);
    localparam logic [OW-1:0] CLR_V = OW'(FLAG_CLR);
    localparam logic [DATA_W-1:0] OTHER_MASK = ~(DATA_W'(1) << FLAG_BIT);

    logic [RW-1:0] run_c;
    logic [OW-1:0] low_run;
    logic [OW-1:0] high_run;

    always_ff @(posedge cpu_clk) begin
        if (rst || !low_cpu)   run_c <= '0;
        else if (run_c != RUN_V) run_c <= run_c + RW'(1);
    end

    always_ff @(posedge osc_clk) begin
        if (rst || !low_osc)     low_run <= '0;
        else if (low_run != MAX_V) low_run <= low_run + OW'(1);
        if (rst || low_osc)       high_run <= '0;
        else if (high_run != CLR_V) high_run <= high_run + OW'(1);
    end

    p_trip_after_run_r1: assert property (@(posedge cpu_clk) disable iff (rst)
        (run_c == RUN_V) |-> lv_reset_req);

    p_release_on_high_r2: assert property (@(posedge cpu_clk) disable iff (rst)
        lv_reset_req |-> (run_c == RUN_V));

    p_flag_rise_window_r3: assert property (@(posedge osc_clk) disable iff (rst)
        $rose(flag_osc) |-> (low_run >= MIN_V) && (low_run <= MAX_V));

    p_flag_forced_r3: assert property (@(posedge osc_clk) disable iff (rst)
        (low_run == MAX_V) |-> flag_osc);

    p_flag_clear_r4: assert property (@(posedge osc_clk) disable iff (rst)
        $fell(flag_osc) |-> (high_run == CLR_V));

    p_rd_value_r5: assert property (@(posedge cpu_clk) disable iff (rst)
        (!$past(rst) && $past(bus_en && !bus_we && bus_addr == STAT_ADDR))
        |-> (bus_rdata[FLAG_BIT] == $past(flag_cpu)));

    p_rd_pad_r5: assert property (@(posedge cpu_clk) disable iff (rst)
        (bus_rdata & OTHER_MASK) == '0);

    p_wr_quiet_r6: assert property (@(posedge cpu_clk) disable iff (rst)
        (!$past(rst) && $past(bus_en && bus_we)) |-> (bus_rdata == '0));

    p_rst_cpu_r7: assert property (@(posedge cpu_clk)
        rst |=> (!lv_reset_req && bus_rdata == '0));

    p_rst_osc_r7: assert property (@(posedge osc_clk)
        rst |=> !flag_osc);
endmodule

bind lowv_guard lowv_guard_chk #(
    .RST_RUN   (RST_RUN),
    .FLAG_CLR  (FLAG_CLR),
    .FLAG_MIN  (32),
    .FLAG_MAX  (40),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .FLAG_BIT  (FLAG_BIT),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .cpu_clk      (cpu_clk),
    .osc_clk      (osc_clk),
    .rst          (rst),
    .low_cpu      (low_cpu),
    .low_osc      (low_osc),
    .flag_osc     (flag_osc),
    .flag_cpu     (flag_cpu),
    .bus_en       (bus_en),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .lv_reset_req (lv_reset_req)
);

// File: tb/lowv_guard_tb.sv
`timescale 1ns/1ps
module lowv_guard_tb;
    localparam logic [15:0] STAT = 16'hFE0F;

    logic        cpu_clk = 1'b0;
    logic        osc_clk = 1'b0;
    logic        rst     = 1'b1;
    logic        vdd_low = 1'b0;
    logic        bus_en  = 1'b0;
    logic        bus_we  = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_rdata;
    logic        lv_reset_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit mon_en  = 1'b0;

    always #4  cpu_clk = ~cpu_clk;
    always #13 osc_clk = ~osc_clk;

    lowv_guard u_dut (
        .cpu_clk      (cpu_clk),
        .osc_clk      (osc_clk),
        .rst          (rst),
        .vdd_low      (vdd_low),
        .bus_en       (bus_en),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_rdata    (bus_rdata),
        .lv_reset_req (lv_reset_req)
    );

    // Requirement model for R1/R2: two sampling stages, then a run of low samples.
    logic m_d1 = 1'b0, m_d2 = 1'b0;
    int   m_run = 0;
    always @(posedge cpu_clk) begin
        if (rst) begin
            m_d1 <= 1'b0; m_d2 <= 1'b0; m_run <= 0;
        end else begin
            m_d1 <= vdd_low;
            m_d2 <= m_d1;
            m_run <= m_d2 ? m_run + 1 : 0;
        end
    end

    function automatic bit exp_req(int run);
        return run >= 9;
    endfunction

    function automatic logic [7:0] exp_rd(bit flag);
        return flag ? 8'h80 : 8'h00;
    endfunction

    always @(negedge cpu_clk) begin
        if (mon_en && !rst) begin
            n_tests++;
            if (lv_reset_req !== exp_req(m_run)) begin
                n_fail++;
                $display("FAIL R1/R2 reset request: actual %b expected %b (run %0d)",
                         lv_reset_req, exp_req(m_run), m_run);
            end
        end
    end

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_cycle(bit we, logic [15:0] a, output logic [7:0] d);
        @(negedge cpu_clk);
        bus_en = 1'b1; bus_we = we; bus_addr = a;
        @(negedge cpu_clk);
        bus_en = 1'b0; bus_we = 1'b0;
        d = bus_rdata;
    endtask

    task automatic osc_wait(int n);
        repeat (n) @(negedge osc_clk);
    endtask

    task automatic cpu_low(int lo, int hi);
        @(negedge cpu_clk);
        vdd_low = 1'b1;
        repeat (lo) @(negedge cpu_clk);
        vdd_low = 1'b0;
        repeat (hi) @(negedge cpu_clk);
    endtask

    // Low burst of L oscillator cycles, then read the flag 4 cycles into the high phase.
    task automatic flag_burst(int len);
        logic [7:0] d;
        @(negedge osc_clk);
        vdd_low = 1'b1;
        osc_wait(len);
        vdd_low = 1'b0;
        osc_wait(4);
        bus_cycle(1'b0, STAT, d);
        if (len < 32)       check8("R3 short low run keeps flag 0", d, exp_rd(1'b0));
        else if (len > 40)  check8("R3 long low run sets flag", d, exp_rd(1'b1));
        osc_wait(45);
        bus_cycle(1'b0, STAT, d);
        check8("R4 flag clear after full high window", d, exp_rd(1'b0));
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd2024));
        repeat (4) @(negedge osc_clk);
        @(negedge cpu_clk);
        rst = 1'b0;
        @(negedge cpu_clk);
        n_tests++;
        if (lv_reset_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R7 reset state req: actual %b expected 0", lv_reset_req);
        end
        check8("R7 reset state rdata", bus_rdata, 8'h00);
        mon_en = 1'b1;

        // R1 boundaries: 8 never trips, 9 trips.
        cpu_low(8, 6);
        cpu_low(9, 6);
        cpu_low(1, 4);
        // R2: trip, one-cycle recovery, then 8 low must not re-trip.
        @(negedge cpu_clk); vdd_low = 1'b1;
        repeat (12) @(negedge cpu_clk);
        vdd_low = 1'b0;
        @(negedge cpu_clk); vdd_low = 1'b1;
        repeat (8) @(negedge cpu_clk);
        vdd_low = 1'b0;
        repeat (6) @(negedge cpu_clk);
        // Random bursts around the R1 threshold.
        for (int i = 0; i < 60; i++) begin
            cpu_low(1 + int'($urandom_range(13)), 1 + int'($urandom_range(3)));
        end
        repeat (6) @(negedge cpu_clk);

        // R3/R4 directed and random flag bursts.
        flag_burst(1);
        flag_burst(31);
        flag_burst(41);
        flag_burst(60);
        for (int i = 0; i < 8; i++) begin
            if ($urandom_range(1) == 0) flag_burst(5 + int'($urandom_range(26)));
            else                        flag_burst(41 + int'($urandom_range(29)));
        end

        // R3 no early set; R4 short high gap keeps flag; R5 addressing; R6 writes.
        @(negedge osc_clk); vdd_low = 1'b1;
        osc_wait(28);
        bus_cycle(1'b0, STAT, d);
        check8("R3 flag still 0 inside low run", d, exp_rd(1'b0));
        osc_wait(30);
        bus_cycle(1'b0, STAT, d);
        check8("R5 read of set flag", d, exp_rd(1'b1));
        bus_cycle(1'b0, 16'hFE0E, d);
        check8("R5 other address reads 0", d, 8'h00);
        bus_cycle(1'b1, STAT, d);
        check8("R6 write cycle returns 0", d, 8'h00);
        bus_cycle(1'b0, STAT, d);
        check8("R6 flag unchanged after write", d, exp_rd(1'b1));
        vdd_low = 1'b0;
        osc_wait(20);
        vdd_low = 1'b1;
        osc_wait(5);
        vdd_low = 1'b0;
        osc_wait(20);
        bus_cycle(1'b0, STAT, d);
        check8("R4 short high gaps keep flag", d, exp_rd(1'b1));
        osc_wait(30);
        bus_cycle(1'b0, STAT, d);
        check8("R4 flag cleared after window", d, exp_rd(1'b0));
        bus_cycle(1'b1, STAT, d);
        check8("R6 write with flag 0", d, 8'h00);

        // R7: reset while low clears flag and request.
        @(negedge osc_clk); vdd_low = 1'b1;
        osc_wait(60);
        bus_cycle(1'b0, STAT, d);
        check8("R7 precondition flag set", d, exp_rd(1'b1));
        @(negedge cpu_clk); rst = 1'b1;
        osc_wait(4);
        @(negedge cpu_clk); rst = 1'b0;
        @(negedge cpu_clk);
        n_tests++;
        if (lv_reset_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R7 req after reset: actual %b expected 0", lv_reset_req);
        end
        bus_cycle(1'b0, STAT, d);
        check8("R7 flag cleared by reset", d, exp_rd(1'b0));
        vdd_low = 1'b0;
        repeat (6) @(negedge cpu_clk);

        mon_en = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule